// File: doc/BRIEF.md
# GPIO Pad Bank with Per-Pin Drive Modes

This block holds up to 32 general-purpose pins behind a simple 32-bit register bus. Each pin's pad behaviour comes from two mode bits (high mode bit and low mode bit) together with one output data bit. The four mode codes give a plain input, a push-pull output, an open-drain output that can only pull low, and an open-source output that can only pull high. For every pin the block drives an output value and an output enable toward the pad cell. It samples the pad input through a two-flop synchronizer.

Software changes output data and mode bits through write-one-to-set and write-one-to-clear registers, so one pin can change without a read-modify-write. Both mode words can also be read back and written whole, which lets software save the pad configuration and restore it later. Every mode write (whole word, set or clear) takes effect only while the external `mode_wr_en` input from a lock is high. Data writes do not depend on that input.

The bus is a single-cycle write strobe with a combinational read mux. The number of implemented pins is a parameter.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset all mode bits and output data bits are 0, so `pad_oe` and `pad_out` are all 0 and both mode words read as 0.
- R2: Reads return the synchronized pad inputs at offset 0x04, the high mode word at 0x08 and the low mode word at 0x0C. Every other offset, including the write-only ones, reads as 0.
- R3: A pin whose mode {high,low} is 00 is an input: `pad_oe` is 0 for both data values.
- R4: A pin with mode 01 is push-pull: `pad_oe` is 1 and `pad_out` equals its data bit.
- R5: A pin with mode 10 is open-drain: data 0 gives `pad_oe`=1 with `pad_out`=0, and data 1 gives `pad_oe`=0.
- R6: A pin with mode 11 is open-source: data 1 gives `pad_oe`=1 with `pad_out`=1, and data 0 gives `pad_oe`=0. `pad_out` is 0 whenever `pad_oe` is 0, in every mode.
- R7: A write to 0x14 sets and a write to 0x18 clears the output data bits at the 1 positions of the write data. A write to 0x54 sets the low mode bits, 0x58 clears the low mode bits and 0x50 clears the high mode bits, again only at the 1 positions. 0 bits leave their bits unchanged.
- R8: While `mode_wr_en` is high, a write to 0x08 or 0x0C replaces the whole high or low mode word.
- R9: While `mode_wr_en` is low, writes to 0x08, 0x0C, 0x50, 0x54 and 0x58 leave both mode words unchanged. Data set and clear writes still take effect.
- R10: A change on `pad_in` appears at offset 0x04 after exactly two rising clock edges.
- R11: Bits at or above `NUM_PINS` read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_en | input | 1 | Enables any write to the mode registers |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Value driven toward each pad |
| pad_oe | output | NUM_PINS | Output enable for each pad |

## Verification
Four neighbouring pins are put in the four different modes, and the output data is then stepped through all-zero, all-one and alternating patterns. These patterns separate the open-drain and open-source modes from push-pull, because each of those two drives in only one data polarity. The set and clear offsets are written with sparse masks, so that any change to an untouched bit shows up. The same mode writes are repeated with the lock enable low, which checks that they are refused while data writes still take effect. A second instance with six pins receives all-ones writes, which shows that its upper bits stay 0.

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr_en,
  input  logic                bus_wen,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int N = NUM_PINS;
  localparam logic [ADDR_W-1:0] OFF_DIN   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_HI    = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_LO    = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_DSET  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_DCLR  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFF_HICLR = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] OFF_LOSET = ADDR_W'(8'h54);
  localparam logic [ADDR_W-1:0] OFF_LOCLR = ADDR_W'(8'h58);

  logic [N-1:0] mode_lo_q, mode_hi_q, dout_q, sync1_q, sync2_q;

  wire [N-1:0] wbits  = bus_wdata[N-1:0];
  wire         mwr    = bus_wen && mode_wr_en;
  wire         hi_dir = mwr && bus_addr == OFF_HI;
  wire         hi_clr = mwr && bus_addr == OFF_HICLR;
  wire         lo_dir = mwr && bus_addr == OFF_LO;
  wire         lo_set = mwr && bus_addr == OFF_LOSET;
  wire         lo_clr = mwr && bus_addr == OFF_LOCLR;
  wire         d_set  = bus_wen && bus_addr == OFF_DSET;
  wire         d_clr  = bus_wen && bus_addr == OFF_DCLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lo_q <= '0;
      mode_hi_q <= '0;
      dout_q    <= '0;
      sync1_q   <= '0;
      sync2_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (d_set)      dout_q <= dout_q | wbits;
      else if (d_clr) dout_q <= dout_q & ~wbits;
      if (hi_dir)      mode_hi_q <= wbits;
      else if (hi_clr) mode_hi_q <= mode_hi_q & ~wbits;
      if (lo_dir)      mode_lo_q <= wbits;
      else if (lo_set) mode_lo_q <= mode_lo_q | wbits;
      else if (lo_clr) mode_lo_q <= mode_lo_q & ~wbits;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      unique case ({mode_hi_q[i], mode_lo_q[i]})
        2'b00: begin pad_oe[i] = 1'b0;       pad_out[i] = 1'b0;      end
        2'b01: begin pad_oe[i] = 1'b1;       pad_out[i] = dout_q[i]; end
        2'b10: begin pad_oe[i] = ~dout_q[i]; pad_out[i] = 1'b0;      end
        default: begin pad_oe[i] = dout_q[i]; pad_out[i] = dout_q[i]; end
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_DIN: bus_rdata[N-1:0] = sync2_q;
      OFF_HI:  bus_rdata[N-1:0] = mode_hi_q;
      OFF_LO:  bus_rdata[N-1:0] = mode_lo_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_wr_en,
  input logic                bus_wen,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] mode_lo,
  input logic [NUM_PINS-1:0] mode_hi,
  input logic [NUM_PINS-1:0] dout,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe
);
  a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~mode_hi & ~mode_lo) == '0);

  a_r5_drain_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & pad_oe & mode_hi & ~mode_lo) == '0);

  a_r6_source_never_low: assert property (@(posedge clk) disable iff (!rst_n)
    (~pad_out & pad_oe & mode_hi & mode_lo) == '0);

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r7_data_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == ADDR_W'(8'h14)
    |=> (dout & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]));

  a_r7_data_clr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen && bus_addr == ADDR_W'(8'h18)
    |=> (dout & $past(bus_wdata[NUM_PINS-1:0])) == '0);

  a_r9_locked_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_en |=> $stable(mode_lo) && $stable(mode_hi));

  generate
    if (NUM_PINS < 32) begin : g_upper
      a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:NUM_PINS] == '0);
    end
  endgenerate
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .bus_wen(bus_wen),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .mode_lo(mode_lo_q), .mode_hi(mode_hi_q), .dout(dout_q),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_gpio_pad_bank.sv
module test_gpio_pad_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr_en = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, nrw_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [5:0]  nrw_out, nrw_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_pad_bank i_gpio_pad_bank (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  gpio_pad_bank #(.NUM_PINS(6)) i_gpio_pad_bank_narrow (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(nrw_rdata),
    .pad_in(pad_in[5:0]), .pad_out(nrw_out), .pad_oe(nrw_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h08, v); check("R1 hi mode", v, 0);
    rd(8'h0C, v); check("R1 lo mode", v, 0);
    check("R1 oe", pad_oe, 0);
    check("R1 out", pad_out, 0);
  endtask

  task automatic t_modes;
    mode_wr_en = 1'b1;
    wr(8'h08, 32'h0000_000C);
    wr(8'h0C, 32'h0000_000A);
    #1;
    check("R8 R3 R4 R5 R6 oe data0", pad_oe[3:0], 4'b0110);
    check("R4 R5 out data0", pad_out[3:0], 4'b0000);
    wr(8'h14, 32'h0000_000F);
    #1;
    check("R4 R5 R6 oe data1", pad_oe[3:0], 4'b1010);
    check("R4 R6 out data1", pad_out[3:0], 4'b1010);
    wr(8'h18, 32'h0000_000A);
    #1;
    check("R3 R4 R5 R6 oe alt", pad_oe[3:0], 4'b0010);
    check("R6 out alt", pad_out[3:0], 4'b0000);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(8'h58, 32'h0000_0002);
    wr(8'h50, 32'h0000_0002);
    rd(8'h0C, v); check("R7 lo clear", v, 32'h8);
    rd(8'h08, v); check("R7 hi clear", v, 32'hC);
    wr(8'h54, 32'h8000_0001);
    rd(8'h0C, v); check("R7 lo set", v, 32'h8000_0009);
    wr(8'h14, 32'h0000_0100);
    wr(8'h18, 32'h0000_0004);
    wr(8'h0C, 32'h0000_0104);
    wr(8'h08, 32'h0);
    #1;
    check("R7 data set clear", pad_out[8:0], 9'h100);
    rd(8'h14, v); check("R2 write-only reads 0", v, 0);
    rd(8'h10, v); check("R2 unmapped reads 0", v, 0);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    mode_wr_en = 1'b0;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R9 lo locked", v, 32'h104);
    rd(8'h08, v); check("R9 hi locked", v, 0);
    wr(8'h14, 32'h0000_0004);
    #1;
    check("R9 data still writes", pad_out[8:0], 9'h104);
  endtask

  task automatic t_sync;
    @(negedge clk);
    bus_addr = 8'h04;
    pad_in = 32'hA5A5_0F0F;
    @(negedge clk);
    check("R10 one edge", bus_rdata, 0);
    @(negedge clk);
    check("R10 two edges", bus_rdata, 32'hA5A5_0F0F);
    check("R11 narrow din", nrw_rdata, 32'h0F);
  endtask

  task automatic t_narrow;
    mode_wr_en = 1'b1;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0);
    @(negedge clk);
    bus_addr = 8'h0C;
    #2;
    check("R11 narrow upper zero", nrw_rdata, 32'h3F);
    check("R8 wide full word", bus_rdata, 32'hFFFF_FFFF);
    check("R11 narrow oe", {26'd0, nrw_oe}, 32'h3F);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_setclr();
    t_locked();
    t_sync();
    t_narrow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule